// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM that accepts a read or a write on every clock cycle, in any order, with no idle cycle between them. The address and the controls are captured on one rising edge. Read data appears one enabled edge later from an output register. Write data is sampled two enabled edges after its address, which is the same bus slot that read data would occupy. Because reads and writes use the same slot, the data bus never needs a turnaround cycle.

A clock enable freezes the whole pipeline. Three chip selects gate new cycles, so several devices can share a bus for depth expansion. An advance control steps a two-bit burst counter in linear or interleaved order, chosen by a static strap. An asynchronous output enable and an asynchronous sleep input control the data drive. The data bus is modelled as separate in and out vectors plus a drive-enable flag. When the flag is low, the output reads as zero.

Top module: `nt_sram`

## Requirements
- R1: After reset, `dq_en_o` is 0, `rdata_o` is 0, no burst is active and the pipeline holds no operation.
- R2: A new cycle is loaded only when `cs_a_i`=1, `cs_b_i`=1, `cs_c_ni`=0 and `adv_i`=0. With `adv_i`=0 and any other chip-select combination, the edge is a deselect: no read or write takes place, and any active burst ends.
- R3: A read accepted at enabled edge N puts the word on `rdata_o` with `dq_en_o`=1 after enabled edge N+1, given `oe_i`=1 and `sleep_i`=0. The word stays there until the next enabled edge. After an enabled edge that did not follow an accepted read, the bus is not driven.
- R4: For a write accepted at enabled edge N, `wdata_i` is sampled at enabled edge N+2. `byte_en_i` is sampled at edge N together with the address. When its bit b is 1, it updates bits [b*BYTE_W +: BYTE_W] of the word. Bytes whose bit is 0 keep their old value.
- R5: Reads and writes may follow each other in any order on consecutive enabled edges. A read whose address matches a write that is still pending returns the newly written bytes merged with the stored ones.
- R6: While `clk_en_i`=0, every input other than `oe_i`, `sleep_i` and `lin_burst_i` is ignored, and all pipeline, burst and output registers hold their values.
- R7: An enabled edge with `adv_i`=1 while a burst is active issues the next beat. The upper address bits stay at the load address. The low two bits are start+k mod 4 when `lin_burst_i`=1, or start XOR k when `lin_burst_i`=0, where k is the beat number. The sequence wraps every four beats.
- R8: During a burst, every beat keeps the read/write type of the load. `we_i` and the chip selects are ignored while `adv_i`=1. `adv_i`=1 with no active burst issues nothing.
- R9: `oe_i`=0 clears `dq_en_o` at once, without waiting for a clock edge, and leaves the pipeline unchanged.
- R10: `sleep_i`=1 clears `dq_en_o` at once. No new cycle is accepted while it is high, and the burst state holds. Operations already in the pipeline complete, and the array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable, active high; low suspends the device |
| cs_a_i | input | 1 | Chip select, active high |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_ni | input | 1 | Chip select, active low |
| we_i | input | 1 | 1 = write, 0 = read, sampled on load |
| byte_en_i | input | NUM_BYTES | Per-byte write enables, active high |
| adv_i | input | 1 | 1 = advance the burst, 0 = load or deselect |
| lin_burst_i | input | 1 | Burst order strap: 1 = linear, 0 = interleaved |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous power-down request |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | NUM_BYTES*BYTE_W | Write data bus |
| rdata_o | output | NUM_BYTES*BYTE_W | Read data bus, zero when not driven |
| dq_en_o | output | 1 | Data bus drive enable |

## Verification
A wrong address in the pipeline or in the burst counter shows at the ports as a wrong word one enabled edge after the read that uses it. A lost or misplaced byte write shows at the first later read of that word. The bench fills the whole array with distinct patterns, so any such error changes the data seen at the ports. A stall that lets a register move shows as changed data or a changed drive flag on the very next sample. A missed bypass shows on a read that follows a write to the same address with no gap.

// File: rtl/nt_sram_pkg.sv
`timescale 1ns/1ps
package nt_sram_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_NEXT  = 2'd2,
    CMD_DESEL = 2'd3
  } cmd_e;

  // low two address bits for beat k of a burst
  function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] k, logic lin);
    return lin ? 2'(start + k) : (start ^ k);
  endfunction

endpackage

// File: rtl/nt_sram_decode.sv
`timescale 1ns/1ps
module nt_sram_decode
  import nt_sram_pkg::*;
(
  input  logic cs_a_i,
  input  logic cs_b_i,
  input  logic cs_c_ni,
  input  logic adv_i,
  input  logic sleep_i,
  input  logic burst_act_i,
  output cmd_e cmd_o
);

  logic sel;
  assign sel = cs_a_i & cs_b_i & ~cs_c_ni;

  always_comb begin
    if (sleep_i)    cmd_o = CMD_NONE;
    else if (adv_i) cmd_o = burst_act_i ? CMD_NEXT : CMD_NONE;
    else if (sel)   cmd_o = CMD_LOAD;
    else            cmd_o = CMD_DESEL;
  end

endmodule

// File: rtl/nt_sram_burst.sv
`timescale 1ns/1ps
module nt_sram_burst
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              lin_i,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_wr_o,
  output logic              act_o
);

  logic              act_q, wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + 2'd1;
  assign act_o   = act_q;

  always_comb begin
    if (cmd_i == CMD_NEXT) begin
      op_addr_o = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, lin_i)};
      op_wr_o   = wr_q;
    end else begin
      op_addr_o = addr_i;
      op_wr_o   = we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      unique case (cmd_i)
        CMD_LOAD: begin
          act_q  <= 1'b1;
          wr_q   <= we_i;
          base_q <= addr_i;
          cnt_q  <= '0;
        end
        CMD_NEXT:  cnt_q <= cnt_nxt;
        CMD_DESEL: act_q <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nt_sram_array.sv
`timescale 1ns/1ps
module nt_sram_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [NUM_BYTES-1:0]        be_i,
  input  logic [ADDR_W-1:0]           waddr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_bank
    logic [BYTE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) bank[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = bank[raddr_i];
  end

endmodule

// File: rtl/nt_sram_rdpath.sv
`timescale 1ns/1ps
module nt_sram_rdpath #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        cap_i,
  input  logic                        hit_i,
  input  logic [NUM_BYTES-1:0]        hit_be_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] arr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0] data_o,
  output logic                        vld_o
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic [DATA_W-1:0] merged;

  // bypass the write that lands on the same edge
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_merge
    assign merged[g*BYTE_W +: BYTE_W] = (hit_i && hit_be_i[g]) ?
        wdata_i[g*BYTE_W +: BYTE_W] : arr_i[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      vld_o  <= 1'b0;
    end else if (en_i) begin
      vld_o <= cap_i;
      if (cap_i) data_o <= merged;
    end
  end

endmodule

// File: rtl/nt_sram.sv
`timescale 1ns/1ps
module nt_sram
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clk_en_i,
  input  logic                        cs_a_i,
  input  logic                        cs_b_i,
  input  logic                        cs_c_ni,
  input  logic                        we_i,
  input  logic [NUM_BYTES-1:0]        byte_en_i,
  input  logic                        adv_i,
  input  logic                        lin_burst_i,
  input  logic                        oe_i,
  input  logic                        sleep_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata_i,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata_o,
  output logic                        dq_en_o
);

  localparam int DATA_W = NUM_BYTES * BYTE_W;

  cmd_e              cmd;
  logic              burst_act;
  logic [ADDR_W-1:0] op_addr;
  logic              op_wr, accept;

  logic                 s1_vld_q, s1_wr_q, s2_vld_q, s2_wr_q;
  logic [ADDR_W-1:0]    s1_addr_q, s2_addr_q;
  logic [NUM_BYTES-1:0] s1_be_q, s2_be_q;

  logic [DATA_W-1:0] arr_rdata, out_q;
  logic              out_vld_q, arr_we, byp_hit;

  nt_sram_decode u_decode (
    .cs_a_i      (cs_a_i),
    .cs_b_i      (cs_b_i),
    .cs_c_ni     (cs_c_ni),
    .adv_i       (adv_i),
    .sleep_i     (sleep_i),
    .burst_act_i (burst_act),
    .cmd_o       (cmd)
  );

  nt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (clk_en_i),
    .cmd_i     (cmd),
    .addr_i    (addr_i),
    .we_i      (we_i),
    .lin_i     (lin_burst_i),
    .op_addr_o (op_addr),
    .op_wr_o   (op_wr),
    .act_o     (burst_act)
  );

  assign accept = (cmd == CMD_LOAD) || (cmd == CMD_NEXT);

  // stage 1: accepted op, stage 2: op waiting for its data slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_wr_q   <= 1'b0;
      s1_addr_q <= '0;
      s1_be_q   <= '0;
      s2_vld_q  <= 1'b0;
      s2_wr_q   <= 1'b0;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
    end else if (clk_en_i) begin
      s1_vld_q  <= accept;
      if (accept) begin
        s1_wr_q   <= op_wr;
        s1_addr_q <= op_addr;
        s1_be_q   <= byte_en_i;
      end
      s2_vld_q  <= s1_vld_q;
      s2_wr_q   <= s1_wr_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
    end
  end

  assign arr_we  = clk_en_i & s2_vld_q & s2_wr_q;
  assign byp_hit = s2_vld_q & s2_wr_q & (s2_addr_q == s1_addr_q);

  nt_sram_array #(
    .ADDR_W    (ADDR_W),
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_array (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .be_i    (s2_be_q),
    .waddr_i (s2_addr_q),
    .wdata_i (wdata_i),
    .raddr_i (s1_addr_q),
    .rdata_o (arr_rdata)
  );

  nt_sram_rdpath #(
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) u_rdpath (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (clk_en_i),
    .cap_i    (s1_vld_q & ~s1_wr_q),
    .hit_i    (byp_hit),
    .hit_be_i (s2_be_q),
    .arr_i    (arr_rdata),
    .wdata_i  (wdata_i),
    .data_o   (out_q),
    .vld_o    (out_vld_q)
  );

  // asynchronous drive control
  assign dq_en_o = out_vld_q & oe_i & ~sleep_i;
  assign rdata_o = dq_en_o ? out_q : '0;

endmodule

// File: rtl/nt_sram_chk.sv
`timescale 1ns/1ps
module nt_sram_chk
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              oe_i,
  input logic              sleep_i,
  input logic              dq_en_o,
  input cmd_e              cmd_i,
  input logic              s1_vld_i,
  input logic              s1_wr_i,
  input logic [ADDR_W-1:0] s1_addr_i,
  input logic [DATA_W-1:0] out_i,
  input logic              out_vld_i
);

  assert_desel_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && cmd_i == CMD_DESEL) |=> !s1_vld_i);

  assert_read_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s1_vld_i && !s1_wr_i) |=> out_vld_i);

  assert_write_slot_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s1_vld_i && s1_wr_i) |=> !out_vld_i);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(out_i) && $stable(out_vld_i) && $stable(s1_addr_i) && $stable(s1_vld_i)));

  assert_burst_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && cmd_i == CMD_NEXT) |=> (s1_addr_i[ADDR_W-1:2] == $past(s1_addr_i[ADDR_W-1:2])));

  assert_burst_type_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && cmd_i == CMD_NEXT) |=> (s1_vld_i && s1_wr_i == $past(s1_wr_i)));

  assert_oe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !dq_en_o);

  assert_sleep_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_en_o);

  assert_sleep_no_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && sleep_i) |=> !s1_vld_i);

endmodule

bind nt_sram nt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_i  (clk_en_i),
  .oe_i      (oe_i),
  .sleep_i   (sleep_i),
  .dq_en_o   (dq_en_o),
  .cmd_i     (cmd),
  .s1_vld_i  (s1_vld_q),
  .s1_wr_i   (s1_wr_q),
  .s1_addr_i (s1_addr_q),
  .out_i     (out_q),
  .out_vld_i (out_vld_q)
);

// File: tb/nt_sram_test.sv
`timescale 1ns/1ps
module nt_sram_test;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b1, cs_a = 1'b0, cs_b = 1'b0, cs_c_n = 1'b1;
  logic          we = 1'b0, adv = 1'b0, lin = 1'b1, oe = 1'b1, sleep = 1'b0;
  logic [NB-1:0] be = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          dq_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nt_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) uut (
    .clk_i (clk), .rst_ni (rst_n), .clk_en_i (clk_en),
    .cs_a_i (cs_a), .cs_b_i (cs_b), .cs_c_ni (cs_c_n),
    .we_i (we), .byte_en_i (be), .adv_i (adv), .lin_burst_i (lin),
    .oe_i (oe), .sleep_i (sleep), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .dq_en_o (dq_en)
  );

  // reference model
  logic [DW-1:0] mm [DEPTH];
  logic          p1_v = 0, p1_w = 0, p2_v = 0, p2_w = 0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;
  logic [NB-1:0] p1_be = '0, p2_be = '0;
  logic          exp_v = 0;
  logic [DW-1:0] exp_d = '0;
  logic          b_act = 0, b_wr = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;

  function automatic logic [DW-1:0] pat(int a);
    return DW'(a + 1) * 36'h9e3779b51 ^ 36'h5a5a5a5a5;
  endfunction

  function automatic logic [AW-1:0] beat_addr(logic [AW-1:0] base, logic [1:0] k, logic l);
    logic [1:0] lo;
    lo = l ? 2'(base[1:0] + k) : (base[1:0] ^ k);
    return {base[AW-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic model_edge();
    logic sel;
    logic nv, nw;
    logic [AW-1:0] na;
    if (!clk_en) return;
    if (p2_v && p2_w)
      for (int b = 0; b < NB; b++)
        if (p2_be[b]) mm[p2_a][b*BW +: BW] = wdata[b*BW +: BW];
    exp_v = p1_v && !p1_w;
    if (exp_v) exp_d = mm[p1_a];
    p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_be = p1_be;
    sel = cs_a && cs_b && !cs_c_n;
    nv = 0; nw = p1_w; na = p1_a;
    if (sleep) begin
      nv = 0;
    end else if (adv) begin
      if (b_act) begin
        b_cnt = b_cnt + 2'd1;
        nv = 1; nw = b_wr; na = beat_addr(b_base, b_cnt, lin);
      end
    end else if (sel) begin
      b_act = 1; b_wr = we; b_base = addr; b_cnt = 0;
      nv = 1; nw = we; na = addr;
    end else begin
      b_act = 0;
    end
    p1_v = nv;
    if (nv) begin p1_w = nw; p1_a = na; p1_be = be; end
  endtask

  task automatic step(input string tag);
    logic drv;
    @(posedge clk);
    model_edge();
    #1;
    drv = exp_v && oe && !sleep;
    check({tag, " drive"}, DW'(dq_en), DW'(drv));
    check({tag, " data"}, rdata, drv ? exp_d : '0);
  endtask

  task automatic idle();
    cs_a = 0; cs_b = 0; cs_c_n = 1; adv = 0; we = 0; be = '1;
  endtask

  task automatic load(input logic w, input logic [AW-1:0] a, input logic [NB-1:0] bmask);
    cs_a = 1; cs_b = 1; cs_c_n = 0; adv = 0; we = w; addr = a; be = bmask;
  endtask

  // data for the write that completes at the next edge
  task automatic feed();
    wdata = p2_v && p2_w ? pat(int'(p2_a) + 100) : '0;
  endtask

  task automatic flush(input string tag);
    idle();
    for (int i = 0; i < 3; i++) begin feed(); step(tag); end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    // R1 reset state
    check("R1 drive", DW'(dq_en), '0);
    check("R1 data", rdata, '0);
    #1 rst_n = 1'b1;

    // R4 fill with full byte enables, back-to-back
    for (int a = 0; a < DEPTH; a++) begin
      load(1, AW'(a), '1); feed(); step("R4 fill");
    end
    flush("R4 fill");

    // R3 back-to-back reads
    for (int a = 0; a < 16; a++) begin
      load(0, AW'(a), '1); feed(); step("R3 read");
    end
    flush("R3 read");

    // R4 partial byte write then read
    load(1, 6'd5, 4'b0101); feed(); step("R4 partial");
    idle(); feed(); step("R4 partial");
    wdata = '1; step("R4 partial");
    load(0, 6'd5, '1); wdata = '0; step("R4 partial");
    idle(); step("R4 partial");
    check("R4 merged word", rdata,
          {pat(105)[DW-1:3*BW], {BW{1'b1}}, pat(105)[2*BW-1:BW], {BW{1'b1}}});
    flush("R4 partial");

    // R5 alternating write/read on one address and its neighbour
    for (int i = 0; i < 12; i++) begin
      load(i[0] ? 1'b0 : 1'b1, AW'(20 + (i >> 2)), 4'(i * 5)); feed(); step("R5 mix");
    end
    flush("R5 mix");

    // R2 each wrong chip-select combination, with writes requested
    for (int c = 0; c < 7; c++) begin
      cs_a = c[0]; cs_b = c[1]; cs_c_n = ~c[2];
      if (c == 3) cs_c_n = 1;
      adv = 0; we = 1; addr = 6'd30; feed(); step("R2 deselect");
    end
    load(0, 6'd30, '1); feed(); step("R2 deselect");
    flush("R2 deselect");

    // R6 stall in the middle of reads
    load(0, 6'd40, '1); step("R6 stall");
    load(0, 6'd41, '1); step("R6 stall");
    clk_en = 0;
    for (int i = 0; i < 4; i++) begin
      load(1, AW'($urandom), 4'($urandom)); wdata = DW'($urandom); step("R6 stall");
    end
    clk_en = 1;
    flush("R6 stall");

    // R7 linear write burst from offset 1, then interleaved read burst
    lin = 1;
    load(1, 6'd9, '1); feed(); step("R7 linear");
    for (int i = 0; i < 5; i++) begin adv = 1; we = 0; feed(); step("R7 linear"); end
    flush("R7 linear");
    lin = 0;
    load(0, 6'd9, '1); step("R7 interleaved");
    for (int i = 0; i < 5; i++) begin adv = 1; step("R7 interleaved"); end
    flush("R7 interleaved");

    // R8 burst ignores we and chip selects; adv with no burst does nothing
    lin = 1;
    load(0, 6'd14, '1); step("R8 type");
    for (int i = 0; i < 3; i++) begin
      adv = 1; we = 1; cs_a = 0; cs_c_n = 1; feed(); step("R8 type");
    end
    idle(); step("R8 type");
    for (int i = 0; i < 3; i++) begin adv = 1; we = 1; feed(); step("R8 no burst"); end
    flush("R8 no burst");

    // R9 asynchronous output enable
    load(0, 6'd3, '1); step("R9 oe");
    idle(); step("R9 oe");
    oe = 0; #0.5;
    check("R9 async off", DW'(dq_en), '0);
    check("R9 async data", rdata, '0);
    oe = 1; #0.5;
    check("R9 async on", rdata, exp_d);
    flush("R9 oe");

    // R10 sleep: writes requested during sleep are dropped
    load(0, 6'd7, '1); step("R10 sleep");
    sleep = 1;
    for (int i = 0; i < 4; i++) begin
      load(1, 6'd7, '1); wdata = '1; step("R10 sleep");
    end
    sleep = 0;
    load(0, 6'd7, '1); step("R10 sleep");
    flush("R10 sleep");

    // random mix: R5 with every feature active
    for (int i = 0; i < 4000; i++) begin
      clk_en = ($urandom % 8) != 0;
      cs_a   = ($urandom % 8) != 0;
      cs_b   = ($urandom % 8) != 0;
      cs_c_n = ($urandom % 8) == 0;
      we     = $urandom % 2;
      be     = NB'($urandom);
      adv    = ($urandom % 4) == 0;
      oe     = ($urandom % 8) != 0;
      sleep  = ($urandom % 32) == 0;
      addr   = AW'($urandom);
      wdata  = {DW'($urandom), 4'($urandom)};
      if (i % 1000 == 0) lin = ~lin;
      step("R5 random");
    end
    clk_en = 1; oe = 1; sleep = 0;
    flush("R5 random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule